// File: doc/BRIEF.md
# Mode-Selected System Clock Divider

This block produces a family of board clocks from one fast source clock using integer counters. The outputs are a processor clock, a half-rate processor clock, a 66 MHz clock, a PCI clock and an interrupt-controller clock. A 48 MHz clock and a reference clock arrive as plain inputs and are passed through under control. Each output has a data bit and an output-enable bit. A deasserted enable stands for a high-impedance pin.

A 3-bit mode code selects one of these behaviours:
- all outputs off;
- reserved, which the block flags as illegal;
- normal operation at 100 or 133 MHz processor speed, with the 48 MHz output on or off;
- test mode, where every output is a power-of-two division of the source, which is then the test clock.

An active-low power-down input drives every output low. When power-down is released, the outputs stay low for a programmable settling interval. After that a lock-done bit rises and all clocks start together.

Mode and power-down changes wait for the end of a divider frame, the cycle in which every counter wraps together. As a result no output is ever cut short.

Top module: `sysClkDivider`

## Requirements
- R1: Mode code 3'b000 (bit 2 = speed select, bit 1 = SEL1, bit 0 = SEL0) deasserts every output enable and drives every data output low.
- R2: Codes 3'b001 and 3'b101 deassert every output enable and raise `illegalCode`. Every other code keeps `illegalCode` low.
- R3: Codes 3'b010 and 3'b011 give periods, in source cycles, of 4 (cpu), 8 (half-rate), 6 (66 MHz), 12 (PCI) and 24 (interrupt clock). `refClk` follows `refIn`.
- R4: Codes 3'b110 and 3'b111 give periods of 3, 6, 6, 12 and 24 source cycles on the same five outputs.
- R5: In the normal codes, bit 0 low deasserts `oe48` and holds `clk48` low. Bit 0 high enables `clk48` and makes it follow `clk48In`.
- R6: Code 3'b100 is test mode, with these periods in source cycles:

  | Output | Period |
  |---|---|
  | cpu | 2 |
  | half-rate | 4 |
  | 66 MHz | 4 |
  | PCI | 8 |
  | `clk48` | 2 |
  | interrupt clock | 16 |

  `refClk` equals the source clock itself.
- R7: Each divided output is high for the first ceil(N/2) cycles of its period N. The /3 output is therefore high 2 cycles and low 1 cycle, and every even ratio gives exactly 50% duty.
- R8: While power-down is in effect, all output enables are asserted and all data outputs are low, for every mode code.
- R9: A new mode code or a power-down request takes effect only at the end of a divider frame. A pulse that has already started always completes its full width.
- R10: After power-down is released, or after reset, `lockDone` first reads high `lockCycles`+2 source cycles after release. All data outputs stay low until then, and power-down clears `lockDone`.
- R11: When the clocks start, all five divided outputs go high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; the test clock in test mode |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 3 | Mode code {speed, SEL1, SEL0} |
| pwrDnN | input | 1 | Active-low power-down |
| lockCycles | input | LOCK_W | Settling interval in source cycles |
| clk48In | input | 1 | 48 MHz source for normal modes |
| refIn | input | 1 | Reference source for normal modes |
| cpuClk | output | 1 | Processor clock data |
| cpuOe | output | 1 | Processor clock enable |
| cpuHalfClk | output | 1 | Half-rate processor clock data |
| cpuHalfOe | output | 1 | Half-rate clock enable |
| clk66 | output | 1 | 66 MHz clock data |
| oe66 | output | 1 | 66 MHz clock enable |
| pciClk | output | 1 | PCI clock data |
| pciOe | output | 1 | PCI clock enable |
| apicClk | output | 1 | Interrupt-controller clock data |
| apicOe | output | 1 | Interrupt-controller clock enable |
| clk48 | output | 1 | 48 MHz output data |
| oe48 | output | 1 | 48 MHz output enable |
| refClk | output | 1 | Reference output data |
| refOe | output | 1 | Reference output enable |
| illegalCode | output | 1 | Reserved mode code in effect |
| lockDone | output | 1 | Settling interval finished |

## Verification
The hardest situation to reach from the ports is a mode request that lands in the middle of a long pulse. Without frame alignment, that pulse would be cut short.

The stimulus waits until the PCI clock has just risen, then changes the code to all-off in that same cycle. It then counts how long the pulse stays high, which must be the full six cycles.

The release from power-down is timed cycle by cycle against `lockCycles`. In the same sample, the bench checks that all divided outputs rise together.

// File: rtl/sysClkDivider_pkg.sv
package sysClkDivider_pkg;
  localparam int NCH        = 6;   // divided channels
  localparam int NOUT       = 7;   // outputs with enables
  localparam int RATIO_W    = 5;
  localparam int FRAME_NORM = 24;
  localparam int FRAME_TEST = 16;
  localparam int FRAME_W    = $clog2(FRAME_NORM);

  localparam int CH_CPU  = 0;
  localparam int CH_HALF = 1;
  localparam int CH_66   = 2;
  localparam int CH_PCI  = 3;
  localparam int CH_APIC = 4;
  localparam int CH_48   = 5;
  localparam int CH_REF  = 6;

  typedef enum logic [2:0] {
    MODE_OFF      = 3'b000,
    MODE_RSV_LO   = 3'b001,
    MODE_S100_NO48 = 3'b010,
    MODE_S100     = 3'b011,
    MODE_TEST     = 3'b100,
    MODE_RSV_HI   = 3'b101,
    MODE_S133_NO48 = 3'b110,
    MODE_S133     = 3'b111
  } modeCode_t;

  typedef struct packed {
    logic                           restart;
    logic                           run;
    logic                           testMode;
    logic                           forceLow;
    logic [NOUT-1:0]                oe;
    logic [NCH-1:0][RATIO_W-1:0]    ratio;
  } divCtrl_t;

  function automatic logic [RATIO_W-1:0] ratioFor(input logic [2:0] code, input int ch);
    logic [RATIO_W-1:0] r;
    if (code == MODE_TEST) begin
      case (ch)
        CH_CPU:  r = 5'd2;
        CH_HALF: r = 5'd4;
        CH_66:   r = 5'd4;
        CH_PCI:  r = 5'd8;
        CH_APIC: r = 5'd16;
        default: r = 5'd2;
      endcase
    end else begin
      case (ch)
        CH_CPU:  r = code[2] ? 5'd3 : 5'd4;
        CH_HALF: r = code[2] ? 5'd6 : 5'd8;
        CH_66:   r = 5'd6;
        CH_PCI:  r = 5'd12;
        CH_APIC: r = 5'd24;
        default: r = 5'd2;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/clkDivider.sv
module clkDivider #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          restart,
  input  logic          run,
  input  logic [RW-1:0] ratio,
  output logic          divOut
);
  logic [RW-1:0] cnt;
  logic [RW:0]   hiLen;

  assign hiLen = ({1'b0, ratio} + 1'b1) >> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cnt <= '0;
    else if (restart || !run)           cnt <= '0;
    else if (cnt == ratio - 1'b1)       cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end

  assign divOut = run && ({1'b0, cnt} < hiLen);
endmodule

// File: rtl/clkModeCtrl.sv
module clkModeCtrl
  import sysClkDivider_pkg::*;
#(
  parameter int LOCK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeSel,
  input  logic              pwrDnN,
  input  logic [LOCK_W-1:0] lockCycles,
  output divCtrl_t          dc,
  output logic [2:0]        activeCode,
  output logic              pdActive,
  output logic              lockOk,
  output logic              illegal
);
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] frameLast;
  logic [LOCK_W-1:0]  lockCnt;
  logic               isNormal, isTest, runNow, boundary;

  assign isNormal  = activeCode[1];
  assign isTest    = (activeCode == MODE_TEST);
  assign runNow    = lockOk && !pdActive && (isNormal || isTest);
  assign frameLast = isTest ? FRAME_W'(FRAME_TEST - 1) : FRAME_W'(FRAME_NORM - 1);
  assign boundary  = !runNow || (frame == frameLast);
  assign illegal   = (activeCode[1:0] == 2'b01);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCode <= MODE_OFF;
      pdActive   <= 1'b1;
      frame      <= '0;
    end else if (boundary) begin
      activeCode <= modeSel;
      pdActive   <= !pwrDnN;
      frame      <= '0;
    end else begin
      frame      <= frame + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockCnt <= '0;
      lockOk  <= 1'b0;
    end else if (pdActive) begin
      lockCnt <= '0;
      lockOk  <= 1'b0;
    end else if (!lockOk) begin
      if (lockCnt == lockCycles) lockOk  <= 1'b1;
      else                       lockCnt <= lockCnt + 1'b1;
    end
  end

  always_comb begin
    dc.restart  = boundary;
    dc.run      = runNow;
    dc.testMode = isTest;
    dc.forceLow = pdActive;
    dc.oe       = '0;
    if (pdActive)      dc.oe = '1;
    else if (isTest)   dc.oe = '1;
    else if (isNormal) begin
      dc.oe        = '1;
      dc.oe[CH_48] = activeCode[0];
    end
    for (int ch = 0; ch < NCH; ch++) dc.ratio[ch] = ratioFor(activeCode, ch);
  end
endmodule

// File: rtl/clkDivPath.sv
module clkDivPath
  import sysClkDivider_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  divCtrl_t        dc,
  input  logic            clk48In,
  input  logic            refIn,
  output logic [NCH-1:0]  divBus,
  output logic [NOUT-1:0] dataBus,
  output logic [NOUT-1:0] oeBus
);
  logic [NOUT-1:0] raw;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_div
    clkDivider #(.RW(RATIO_W)) i_div (
      .clk     (clk),
      .rstN    (rstN),
      .restart (dc.restart),
      .run     (dc.run),
      .ratio   (dc.ratio[ch]),
      .divOut  (divBus[ch])
    );
  end

  always_comb begin
    raw[CH_APIC:CH_CPU] = divBus[CH_APIC:CH_CPU];
    raw[CH_48]  = dc.testMode ? divBus[CH_48] : (clk48In && dc.run);
    raw[CH_REF] = (dc.testMode ? clk : refIn) && dc.run;
  end

  assign oeBus   = dc.oe;
  assign dataBus = (dc.forceLow) ? '0 : (raw & dc.oe);
endmodule

// File: rtl/sysClkDivider.sv
module sysClkDivider
  import sysClkDivider_pkg::*;
#(
  parameter int LOCK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeSel,
  input  logic              pwrDnN,
  input  logic [LOCK_W-1:0] lockCycles,
  input  logic              clk48In,
  input  logic              refIn,
  output logic              cpuClk,
  output logic              cpuOe,
  output logic              cpuHalfClk,
  output logic              cpuHalfOe,
  output logic              clk66,
  output logic              oe66,
  output logic              pciClk,
  output logic              pciOe,
  output logic              apicClk,
  output logic              apicOe,
  output logic              clk48,
  output logic              oe48,
  output logic              refClk,
  output logic              refOe,
  output logic              illegalCode,
  output logic              lockDone
);
  divCtrl_t        dc;
  logic [2:0]      activeCode;
  logic            pdActive;
  logic [NCH-1:0]  divBus;
  logic [NOUT-1:0] dataBus, oeBus;

  clkModeCtrl #(.LOCK_W(LOCK_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .pwrDnN     (pwrDnN),
    .lockCycles (lockCycles),
    .dc         (dc),
    .activeCode (activeCode),
    .pdActive   (pdActive),
    .lockOk     (lockDone),
    .illegal    (illegalCode)
  );

  clkDivPath i_path (
    .clk     (clk),
    .rstN    (rstN),
    .dc      (dc),
    .clk48In (clk48In),
    .refIn   (refIn),
    .divBus  (divBus),
    .dataBus (dataBus),
    .oeBus   (oeBus)
  );

  assign {refClk, clk48, apicClk, pciClk, clk66, cpuHalfClk, cpuClk} = dataBus;
  assign {refOe,  oe48,  apicOe,  pciOe,  oe66,  cpuHalfOe,  cpuOe } = oeBus;
endmodule

// File: rtl/sysClkDivider_chk.sv
module sysClkDivider_chk
  import sysClkDivider_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic [2:0]      activeCode,
  input logic            pdActive,
  input logic            lockDone,
  input logic            illegalCode,
  input logic            run,
  input logic [NCH-1:0]  divBus,
  input logic [NOUT-1:0] dataBus,
  input logic [NOUT-1:0] oeBus
);
  // R1: all-off code leaves every pin undriven
  a_r1_off_hiz: assert property (@(posedge clk) disable iff (!rstN)
    (activeCode == MODE_OFF && !pdActive) |-> (oeBus == '0 && dataBus == '0));

  // R2: reserved code flagged and undriven
  a_r2_reserved_off: assert property (@(posedge clk) disable iff (!rstN)
    (illegalCode && !pdActive) |-> (oeBus == '0));

  // R8: power-down drives everything low
  a_r8_pd_low: assert property (@(posedge clk) disable iff (!rstN)
    pdActive |-> (dataBus == '0 && oeBus == '1));

  // R9: code changes while running only after every divider finished its period
  a_r9_frame_edge: assert property (@(posedge clk) disable iff (!rstN)
    ($past(run) && !$stable(activeCode)) |-> ($past(divBus) == '0));

  // R10: outputs stay low until lock is done
  a_r10_low_until_lock: assert property (@(posedge clk) disable iff (!rstN)
    !lockDone |-> (dataBus == '0));

  // R10: lock status drops only after power-down
  a_r10_lock_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockDone) |-> $past(pdActive));

  // R11: all dividers start high together
  a_r11_common_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(run) |-> (divBus == '1));
endmodule

bind sysClkDivider sysClkDivider_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .activeCode  (activeCode),
  .pdActive    (pdActive),
  .lockDone    (lockDone),
  .illegalCode (illegalCode),
  .run         (dc.run),
  .divBus      (divBus),
  .dataBus     (dataBus),
  .oeBus       (oeBus)
);

// File: tb/test_sysClkDivider.sv
module test_sysClkDivider;
  localparam int LW = 16;
  localparam int WATCH = 200000;

  logic clk = 1'b0, rstN = 1'b0, pwrDnN = 1'b1, clk48In = 1'b0, refIn = 1'b0;
  logic [2:0] modeSel = 3'b011;
  logic [LW-1:0] lockCycles = 16'd5;
  logic cpuClk, cpuOe, cpuHalfClk, cpuHalfOe, clk66, oe66, pciClk, pciOe;
  logic apicClk, apicOe, clk48, oe48, refClk, refOe, illegalCode, lockDone;

  int checks = 0, errors = 0, cyc = 0;
  logic done = 1'b0;

  typedef struct { int ch; int hi; int lo; string req; } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  sysClkDivider #(.LOCK_W(LW)) i_sysClkDivider (.*);

  wire [6:0] dataV = {refClk, clk48, apicClk, pciClk, clk66, cpuHalfClk, cpuClk};
  wire [6:0] oeV   = {refOe, oe48, apicOe, pciOe, oe66, cpuHalfOe, cpuOe};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic logic chBit(input int ch);
    case (ch)
      0: return cpuClk;
      1: return cpuHalfClk;
      2: return clk66;
      3: return pciClk;
      4: return apicClk;
      default: return clk48;
    endcase
  endfunction

  // expected enable pattern from R1, R2, R5, R6
  function automatic logic [6:0] expOe(input logic [2:0] c);
    if (c == 3'b000 || c[1:0] == 2'b01) return 7'b0;
    if (c == 3'b100) return 7'h7f;
    return {1'b1, c[0], 5'b11111};
  endfunction

  // driver side: push expected period shapes for a mode
  task automatic pushMode(input logic [2:0] c);
    int r[6];
    string req;
    if (c == 3'b100) begin r = '{2, 4, 4, 8, 16, 2}; req = "R6"; end
    else if (c[2])   begin r = '{3, 6, 6, 12, 24, 0}; req = "R4"; end
    else             begin r = '{4, 8, 6, 12, 24, 0}; req = "R3"; end
    for (int ch = 0; ch < 6; ch++)
      if (r[ch] != 0)
        expQ.push_back('{ch, (r[ch] + 1) / 2, r[ch] / 2, (r[ch] == 3) ? "R7" : req});
  endtask

  // monitor side: measure each queued channel and compare
  task automatic monitor();
    while (expQ.size() > 0) begin
      exp_t e = expQ.pop_front();
      int g = 0, hi = 0, lo = 0;
      while (chBit(e.ch) !== 1'b0 && g < 100) begin tick(); g++; end
      while (chBit(e.ch) !== 1'b1 && g < 200) begin tick(); g++; end
      while (chBit(e.ch) === 1'b1 && g < 300) begin hi++; tick(); g++; end
      while (chBit(e.ch) === 1'b0 && g < 400) begin lo++; tick(); g++; end
      check(hi == e.hi, {e.req, " high width"}, hi, e.hi);
      check(lo == e.lo, {e.req, " low width"}, lo, e.lo);
    end
  endtask

  initial begin
    while (!done && cyc < WATCH) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog R0 actual=%0d expected=%0d", cyc, WATCH);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, first;
    ticks(3);
    // reset state: power-down style, outputs low, no lock (R8, R10)
    check(dataV == 7'b0, "R8 reset data", dataV, 0);
    check(lockDone == 1'b0, "R10 reset lock", lockDone, 0);

    // R10 / R11: release and time the lock
    rstN = 1'b1;
    first = 0;
    for (n = 1; n <= 20 && first == 0; n++) begin
      tick();
      if (lockDone === 1'b1) first = n;
      else if (dataV != 7'b0) check(1'b0, "R10 low during lock", dataV, 0);
    end
    check(first == 7, "R10 lock time", first, 7);
    check({apicClk, pciClk, clk66, cpuHalfClk, cpuClk} == 5'b11111, "R11 common start",
          {apicClk, pciClk, clk66, cpuHalfClk, cpuClk}, 31);

    // R3 normal 100
    pushMode(3'b011); monitor();
    clk48In = 1'b1; refIn = 1'b1; #1;
    check(clk48 == 1'b1 && oe48 == 1'b1, "R5 48 passes", clk48, 1);
    check(refClk == 1'b1, "R3 ref follows", refClk, 1);
    refIn = 1'b0; #1;
    check(refClk == 1'b0, "R3 ref follows low", refClk, 0);

    // R5 48 off
    modeSel = 3'b010; ticks(30);
    check(oe48 == 1'b0 && clk48 == 1'b0, "R5 48 gated", {oe48, clk48}, 0);
    pushMode(3'b010); monitor();

    // R4 / R7 normal 133
    modeSel = 3'b111; ticks(30);
    pushMode(3'b111); monitor();

    // R6 test mode
    modeSel = 3'b100; ticks(30);
    pushMode(3'b100); monitor();
    @(posedge clk); #1;
    check(refClk == 1'b1, "R6 ref high phase", refClk, 1);
    @(negedge clk); #1;
    check(refClk == 1'b0, "R6 ref low phase", refClk, 0);

    // R1 / R2 / R5: sweep all eight codes
    for (int c = 0; c < 8; c++) begin
      modeSel = 3'(c); ticks(30);
      check(oeV == expOe(3'(c)), $sformatf("R%0d enables code %0d", (c[1:0] == 2'b01) ? 2 : 1, c),
            oeV, expOe(3'(c)));
      check(illegalCode == (c[1:0] == 2'b01), "R2 illegal flag", illegalCode, (c[1:0] == 2'b01));
      if (expOe(3'(c)) == 7'b0) check(dataV == 7'b0, "R1 data low when off", dataV, 0);
    end

    // R9: request all-off right after a PCI rise; pulse must complete
    modeSel = 3'b011; ticks(30);
    n = 0;
    while (pciClk !== 1'b0 && n < 50) begin tick(); n++; end
    while (pciClk !== 1'b1 && n < 100) begin tick(); n++; end
    modeSel = 3'b000;
    n = 0;
    while (pciClk === 1'b1 && n < 40) begin n++; tick(); end
    check(n == 6, "R9 full pulse", n, 6);
    ticks(30);
    check(oeV == 7'b0, "R9 change applied", oeV, 0);

    // R8: power-down in every code
    modeSel = 3'b011; ticks(40);
    pwrDnN = 1'b0;
    for (int c = 0; c < 8; c++) begin
      modeSel = 3'(c); ticks(30);
      check(oeV == 7'h7f && dataV == 7'b0, "R8 pd forces low", {oeV, dataV}, 16256);
    end
    check(lockDone == 1'b0, "R10 pd clears lock", lockDone, 0);

    // R10: release with different interval
    lockCycles = 16'd3; modeSel = 3'b111; pwrDnN = 1'b1;
    first = 0;
    for (n = 1; n <= 20 && first == 0; n++) begin
      tick();
      if (lockDone === 1'b1) first = n;
    end
    check(first == 5, "R10 lock time short", first, 5);
    check(cpuClk == 1'b1 && apicClk == 1'b1, "R11 restart high", {cpuClk, apicClk}, 3);
    pushMode(3'b111); monitor();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule